// File: doc/BRIEF.md
# Monotonic SAR Controller with Rotating Unit-Element Selection

This block sequences a 10-bit successive-approximation conversion for a differential charge-redistribution array. A `start` pulse opens a one-cycle sampling window. After that, each comparator decision is taken on a `cmp_rdy` strobe. Switching is monotonic: after each decision only one side of the array moves. A decision of 1 switches positive-side elements to ground and leaves the negative side alone. A decision of 0 switches only negative-side elements.

The first five decisions each switch a group of unit elements: 16, then 8, 4, 2 and 1. Each group is taken from a 32-element pool per side, as a run of consecutive positions that starts at that side's pointer. The pointer then advances by the group size and wraps modulo 32. The next four decisions each set one binary-weighted enable on the chosen side. The tenth decision only sets the last code bit.

In rotating mode the pointers carry over from one conversion to the next. A given step therefore lands on different elements each time, which spreads mismatch error. In fixed mode both pointers restart at zero on every conversion, so a given code always selects the same elements.

Top module: `sar_rot_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, `sample`, `done`, `code`, all element enables and both pointers are zero.
- R2: A `start` seen while idle makes `sample` high for exactly the next cycle. In that cycle `code` and all four enable vectors read zero.
- R3: A `cmp_rdy` strobe while idle changes no output. A `start` while a conversion is running is ignored: `sample` stays low and the result is unaffected.
- R4: Decision k (k = 0 for the first) is written to `code[9-k]`, so bit 9 is the MSB.
- R5: A decision of 1 changes only the positive-side enables (`unit_p`, `bin_p`). A decision of 0 changes only the negative-side enables. Enables never clear during a conversion.
- R6: Decisions 0 to 4 switch 16, 8, 4, 2 and 1 unit elements. A group of n covers the positions ptr, ptr+1, ... ptr+n-1 modulo 32 of the chosen side, where bit i of `unit_*` is position i. That side's pointer then advances by n, modulo 32.
- R7: Decisions 5 to 8 set bit 3, 2, 1 and 0 of `bin_p` or `bin_n` on the chosen side. Decision 9 switches nothing.
- R8: `done` is high for exactly the one cycle after the edge that takes the tenth decision. `code` and the enables then hold until the next `start`.
- R9: With `rotate` high at `start`, both pointers keep their values from the previous conversion. Two back-to-back conversions of code 10'h3FF therefore select different positive unit elements.
- R10: With `rotate` low at `start`, both pointers restart at zero. A repeated code gives identical enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (honoured only while idle) |
| rotate | input | 1 | 1: rotating pointers, 0: fixed selection (taken at start) |
| cmp_rdy | input | 1 | Comparator decision strobe |
| cmp_out | input | 1 | Comparator decision |
| sample | output | 1 | Sampling window, one cycle |
| unit_p | output | 32 | Positive-side unit-element enables |
| unit_n | output | 32 | Negative-side unit-element enables |
| bin_p | output | 4 | Positive-side binary-weighted enables |
| bin_n | output | 4 | Negative-side binary-weighted enables |
| done | output | 1 | Conversion complete, one-cycle pulse |
| code | output | 10 | Conversion result, bit 9 is the MSB |

## Verification
`sample` is due one cycle after the edge that takes `start`. Each decision's effect on the enables appears right after the edge that takes its strobe, and `done` follows the edge that takes the tenth strobe. The driver works on falling edges. It checks `sample` in the falling edge right after the start edge and checks it low one cycle later. It checks `done` low after each of the first nine strobes, high after the tenth, and low again one cycle later. The scoreboard monitor pops an expected code and enable set on the falling edge where `done` is high. The bench's own pointer model builds that expected set, and the bench varies the spacing between strobes.

// File: rtl/sar_rot_ctrl.sv
module sar_rot_ctrl #(
  parameter int NBITS  = 10,
  parameter int NUNARY = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      rotate,
  input  logic                      cmp_rdy,
  input  logic                      cmp_out,
  output logic                      sample,
  output logic [(1<<NUNARY)-1:0]    unit_p,
  output logic [(1<<NUNARY)-1:0]    unit_n,
  output logic [NBITS-NUNARY-2:0]   bin_p,
  output logic [NBITS-NUNARY-2:0]   bin_n,
  output logic                      done,
  output logic [NBITS-1:0]          code
);
  localparam int POOL = 1 << NUNARY;
  localparam int PW   = NUNARY;
  localparam int NBIN = NBITS - NUNARY - 1;
  localparam int SW   = $clog2(NBITS);
  localparam logic [SW-1:0] LAST  = SW'(NBITS - 1);
  localparam logic [SW-1:0] NU    = SW'(NUNARY);
  localparam logic [SW-1:0] TOPU  = SW'(NUNARY - 1);
  localparam logic [SW-1:0] TOPB  = SW'(NBITS - 2);

  typedef enum logic [1:0] {IDLE, SAMP, CONV} st_t;

  st_t             st;
  logic [SW-1:0]   step;
  logic [PW-1:0]   ptr_p, ptr_n;
  logic [PW:0]     ucnt;
  logic [POOL-1:0] win_p, win_n;
  logic [NBIN-1:0] bstep;
  logic [NBITS-1:0] cbit;
  logic            take;

  function automatic logic [POOL-1:0] window(input logic [PW-1:0] p, input logic [PW:0] n);
    logic [POOL-1:0] w;
    for (int i = 0; i < POOL; i++) begin
      logic [PW-1:0] d;
      d = PW'(i) - p;
      w[i] = {1'b0, d} < n;
    end
    return w;
  endfunction

  assign take   = (st == CONV) && cmp_rdy;
  assign sample = (st == SAMP);
  assign ucnt   = (step < NU) ? ((PW+1)'(1) << (TOPU - step)) : '0;
  assign win_p  = window(ptr_p, ucnt);
  assign win_n  = window(ptr_n, ucnt);
  assign bstep  = (step >= NU && step < LAST) ? (NBIN'(1) << (TOPB - step)) : '0;
  assign cbit   = NBITS'(1) << (LAST - step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      step   <= '0;
      ptr_p  <= '0;
      ptr_n  <= '0;
      unit_p <= '0;
      unit_n <= '0;
      bin_p  <= '0;
      bin_n  <= '0;
      code   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st     <= SAMP;
          step   <= '0;
          unit_p <= '0;
          unit_n <= '0;
          bin_p  <= '0;
          bin_n  <= '0;
          code   <= '0;
          if (!rotate) begin
            ptr_p <= '0;
            ptr_n <= '0;
          end
        end
        SAMP: st <= CONV;
        CONV: if (take) begin
          if (cmp_out) begin
            code   <= code | cbit;
            unit_p <= unit_p | win_p;
            bin_p  <= bin_p | bstep;
            ptr_p  <= ptr_p + ucnt[PW-1:0];
          end else begin
            unit_n <= unit_n | win_n;
            bin_n  <= bin_n | bstep;
            ptr_n  <= ptr_n + ucnt[PW-1:0];
          end
          if (step == LAST) begin
            st   <= IDLE;
            done <= 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module sar_rot_ctrl_chk #(
  parameter int NBITS  = 10,
  parameter int NUNARY = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample,
  input logic                    done,
  input logic [(1<<NUNARY)-1:0]  unit_p,
  input logic [(1<<NUNARY)-1:0]  unit_n,
  input logic [NBITS-NUNARY-2:0] bin_p,
  input logic [NBITS-NUNARY-2:0] bin_n
);
  localparam int POOL = 1 << NUNARY;

  assert_sample_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> !sample);

  assert_never_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |-> (((unit_p & $past(unit_p)) == $past(unit_p)) &&
                 ((unit_n & $past(unit_n)) == $past(unit_n))));

  assert_one_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |-> !(((unit_p != $past(unit_p)) || (bin_p != $past(bin_p))) &&
                  ((unit_n != $past(unit_n)) || (bin_n != $past(bin_n)))));

  assert_unit_total_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(unit_p) + $countones(unit_n) == POOL - 1));

  assert_bin_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (((bin_p ^ bin_n) == '1) && ((bin_p & bin_n) == '0)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sar_rot_ctrl sar_rot_ctrl_chk #(.NBITS(NBITS), .NUNARY(NUNARY)) chk_i (
  .clk(clk), .rst_n(rst_n), .sample(sample), .done(done),
  .unit_p(unit_p), .unit_n(unit_n), .bin_p(bin_p), .bin_n(bin_n)
);

// File: tb/sar_rot_ctrl_tb.sv
`timescale 1ns/1ps
module sar_rot_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rotate = 1'b1, cmp_rdy = 1'b0, cmp_out = 1'b0;
  logic sample, done;
  logic [31:0] unit_p, unit_n;
  logic [3:0]  bin_p, bin_n;
  logic [9:0]  code;

  typedef struct packed {
    logic [9:0] c; logic [31:0] up, un; logic [3:0] bp, bn;
  } exp_t;

  exp_t q[$];
  exp_t obs;
  int nchk = 0, nfail = 0;
  logic [4:0] mp = '0, mn = '0;

  always #2.5 clk = ~clk;

  sar_rot_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rotate(rotate), .cmp_rdy(cmp_rdy),
    .cmp_out(cmp_out), .sample(sample), .unit_p(unit_p), .unit_n(unit_n),
    .bin_p(bin_p), .bin_n(bin_n), .done(done), .code(code)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      if (q.size() == 0) begin
        chk(1'b0, "R8 unexpected done", 64'(code), 64'h0);
      end else begin
        e = q.pop_front();
        chk(code == e.c, "R4 code", 64'(code), 64'(e.c));
        chk(unit_p == e.up, "R6 unit_p", 64'(unit_p), 64'(e.up));
        chk(unit_n == e.un, "R5 unit_n", 64'(unit_n), 64'(e.un));
        chk({bin_p, bin_n} == {e.bp, e.bn}, "R7 binary enables", 64'({bin_p, bin_n}), 64'({e.bp, e.bn}));
      end
      obs.c = code; obs.up = unit_p; obs.un = unit_n; obs.bp = bin_p; obs.bn = bin_n;
    end
  end

  task automatic run_conv(input logic rot, input logic [9:0] c, input int gap, input bit poke);
    exp_t e;
    e = '0;
    e.c = c;
    if (!rot) begin mp = '0; mn = '0; end
    for (int s = 0; s < 9; s++) begin
      logic b;
      b = c[9-s];
      if (s < 5) begin
        int n;
        n = 16 >> s;
        for (int i = 0; i < 32; i++) begin
          if (((i - (b ? int'(mp) : int'(mn))) & 31) < n) begin
            if (b) e.up[i] = 1'b1; else e.un[i] = 1'b1;
          end
        end
        if (b) mp = mp + 5'(n); else mn = mn + 5'(n);
      end else begin
        if (b) e.bp[8-s] = 1'b1; else e.bn[8-s] = 1'b1;
      end
    end
    q.push_back(e);
    @(negedge clk); rotate = rot; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(sample == 1'b1, "R2 sample high", 64'(sample), 64'h1);
    chk(unit_p == 0 && unit_n == 0 && bin_p == 0 && bin_n == 0 && code == 0,
        "R2 cleared at sample", 64'(unit_p | unit_n), 64'h0);
    @(negedge clk);
    chk(sample == 1'b0, "R2 sample one cycle", 64'(sample), 64'h0);
    for (int s = 0; s < 10; s++) begin
      repeat (gap) @(negedge clk);
      if (poke && s == 3) start = 1'b1;
      cmp_rdy = 1'b1; cmp_out = c[9-s];
      @(negedge clk);
      cmp_rdy = 1'b0; start = 1'b0;
      if (poke) chk(sample == 1'b0, "R3 start ignored mid-conversion", 64'(sample), 64'h0);
      if (s < 9) chk(done == 1'b0, "R8 no early done", 64'(done), 64'h0);
    end
    chk(done == 1'b1, "R8 done after tenth decision", 64'(done), 64'h1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", 64'(done), 64'h0);
    repeat (2) @(negedge clk);
    chk(code == c, "R8 code holds", 64'(code), 64'(c));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'h0, 64'h1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    exp_t a;
    repeat (3) @(negedge clk);
    chk(sample == 0 && done == 0 && code == 0 && unit_p == 0 && unit_n == 0 && bin_p == 0 && bin_n == 0,
        "R1 reset state", 64'(code), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sample == 0 && done == 0 && code == 0 && unit_p == 0, "R1 after release", 64'(unit_p), 64'h0);
    for (int k = 0; k < 3; k++) begin
      cmp_rdy = 1'b1; cmp_out = 1'(k);
      @(negedge clk);
    end
    cmp_rdy = 1'b0;
    chk(unit_p == 0 && unit_n == 0 && code == 0 && done == 0 && sample == 0,
        "R3 idle strobes ignored", 64'(unit_p | unit_n), 64'h0);

    run_conv(1'b1, 10'h3FF, 0, 1'b0);
    a = obs;
    run_conv(1'b1, 10'h3FF, 0, 1'b0);
    chk(obs.up != a.up, "R9 rotation changes selection", 64'(obs.up), 64'(a.up));
    run_conv(1'b1, 10'h000, 1, 1'b0);
    run_conv(1'b1, 10'h2AA, 2, 1'b1);
    run_conv(1'b1, 10'h155, 0, 1'b0);
    run_conv(1'b1, 10'h200, 3, 1'b0);
    run_conv(1'b0, 10'h2AA, 0, 1'b0);
    a = obs;
    run_conv(1'b1, 10'h1C3, 1, 1'b0);
    run_conv(1'b0, 10'h2AA, 0, 1'b0);
    chk(obs == a, "R10 fixed mode repeats", 64'(obs.up), 64'(a.up));
    run_conv(1'b1, 10'h0F0, 0, 1'b0);
    run_conv(1'b1, 10'h3C1, 2, 1'b0);
    chk(q.size() == 0, "R8 all results seen", 64'(q.size()), 64'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule